// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 512K x 8 asynchronous static RAM. The host issues one read or one write at a time over a valid/ready port. The controller turns each request into the active-low chip-select, output-enable and write-strobe sequence the memory needs. It drives a 19-bit address and handles the 8-bit shared data bus through separate output, input and driver-enable signals.

Every analog timing limit of the memory is supplied in nanoseconds as a parameter, together with the clock period. Each limit becomes a whole number of cycles by rounding up. Writes are ended by the write strobe while output-enable stays high, which allows the shorter strobe width. Before the controller drives the data bus, it waits until the memory has had time to release the bus after a read. Between requests the memory is deselected so that it drops into standby.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, the chip-select, output-enable and write-strobe outputs are all high (inactive), the bus driver is off, `rd_valid` is low and `req_ready` is high.
- R2: While `req_ready` is high, the memory is deselected: chip-select, output-enable and write strobe are high and the data driver is off.
- R3: `req_ready` is high only when no transfer is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Address and write data are latched at that edge, so later changes on the request inputs do not affect the transfer.
- R4: A read holds chip-select and output-enable low with the write strobe high for RD cycles, where RD = max(ceil(tAA/Tclk), ceil(tOE/Tclk), 1) + 1. The address stays stable for those cycles. The bus is sampled on the last edge of the read, and `rd_data` appears together with a `rd_valid` pulse one cycle long. The first cycle of `rd_valid` comes RD cycles after the accepting edge.
- R5: A write holds chip-select low and the address stable. The write strobe is high for AS = max(ceil(tSA/Tclk),1) cycles, then low for WP = max(ceil(tWP/Tclk), ceil(tDS/Tclk), 1) cycles, then high for REC = max(ceil(tWC/Tclk) - AS - WP, 1) recovery cycles before idle. Without a turnaround wait, `req_ready` returns AS+WP+REC cycles after the accepting edge.
- R6: The data driver is on only while chip-select is low and output-enable is high. It carries the latched write data, and it turns off on the same edge at which the write strobe rises.
- R7: The data driver turns on only after output-enable has been high for TURN = ceil(tHZ/Tclk) consecutive cycles. A write accepted right after a read therefore waits for extra cycles, and the memory and the controller never drive the bus together.
- R8: Output-enable stays high whenever the write strobe is low.
- R9: After a write, a read of the same address returns the written byte, including when the two requests come back to back. An address that was never written returns whatever the memory holds there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the request |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Controller idle and able to take a request |
| rd_data | output | 8 | Read result |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| sram_addr | output | 19 | Memory address |
| sram_dq_out | output | 8 | Data to the memory bus |
| sram_dq_in | input | 8 | Data from the memory bus |
| sram_dq_oe | output | 1 | Enable of the controller's data driver |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |

## Verification
The assertions check, on every cycle, the relations among the strobes: deselection while ready, output-enable high under a low write strobe, a driver that is on only with output-enable high, driver release on the write-strobe rise, the minimum strobe width, the turnaround count and a stable address. Only the bench's memory model and scenarios can show the timing against the memory's own behaviour: reads sampled too early return corrupted bytes, a driver that overlaps a read's release window is reported as contention, and data written is returned by a later read. Cycle latencies, the behaviour of back-to-back pairs and the handling of request inputs changed after acceptance are likewise shown only by the bench.

// File: rtl/async_sram_pkg.sv
package async_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD     = 3'd1,
        ST_WTURN  = 3'd2,
        ST_WSET   = 3'd3,
        ST_WPULSE = 3'd4,
        ST_WREC   = 3'd5
    } seq_state_t;

    // Pin levels a sequencer state asks for (strobes active low).
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    // Round a nanosecond limit up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        if (ns <= 0) return 0;
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic strobe_t decode_strobes(input seq_state_t s);
        strobe_t p;
        p = STROBE_IDLE;
        case (s)
            ST_RD:     p = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            ST_WTURN:  p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            ST_WSET:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b1};
            ST_WPULSE: p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_WREC:   p = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
            default:   p = STROBE_IDLE;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import async_sram_pkg::*;
#(
    parameter int CNT_W   = 2,
    parameter int AS_CYC  = 1,
    parameter int WP_CYC  = 1,
    parameter int REC_CYC = 1,
    parameter int RD_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    input  logic             turn_ok,
    output seq_state_t       st_q,
    output seq_state_t       st_d,
    output logic             ld,
    output logic [CNT_W-1:0] ld_val,
    output logic             req_ready,
    output logic             accept
);
    function automatic int phase_len(input seq_state_t s);
        case (s)
            ST_RD:     return RD_CYC;
            ST_WSET:   return AS_CYC;
            ST_WPULSE: return WP_CYC;
            ST_WREC:   return REC_CYC;
            default:   return 1;
        endcase
    endfunction

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)   st_d = ST_RD;
                    else if (turn_ok) st_d = ST_WSET;
                    else              st_d = ST_WTURN;
                end
            end
            ST_RD:     if (phase_done) st_d = ST_IDLE;
            ST_WTURN:  if (turn_ok)    st_d = ST_WSET;
            ST_WSET:   if (phase_done) st_d = ST_WPULSE;
            ST_WPULSE: if (phase_done) st_d = ST_WREC;
            ST_WREC:   if (phase_done) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    assign ld     = (st_d != st_q);
    assign ld_val = CNT_W'(phase_len(st_d) - 1);

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // R5: the low strobe phase is only ever entered from the setup phase
    a_r5_pulse_after_setup: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WPULSE) |-> ($past(st_q) == ST_WSET || $past(st_q) == ST_WPULSE));

    // R3: a new request is only taken from idle
    a_r3_leave_idle_on_request: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_IDLE && st_q != ST_IDLE) |-> $past(req_valid));

endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs
    import async_sram_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DATA_W   = 8,
    parameter int TURN_CYC = 1,
    parameter int WP_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  seq_state_t        st_q,
    input  seq_state_t        st_d,
    input  logic [DATA_W-1:0] dq_in,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              turn_ok
);
    localparam int TCNT_W = $clog2(TURN_CYC + 2);
    localparam int WCNT_W = $clog2(WP_CYC + 2);

    strobe_t pins_q;

    always_ff @(posedge clk) begin
        if (rst) pins_q <= STROBE_IDLE;
        else     pins_q <= decode_strobes(st_d);
    end

    assign ce_n  = pins_q.ce_n;
    assign oe_n  = pins_q.oe_n;
    assign we_n  = pins_q.we_n;
    assign dq_oe = pins_q.drive;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            dq_out <= '0;
        end else if (accept) begin
            addr   <= req_addr;
            dq_out <= req_wdata;
        end
    end

    logic rd_last;
    assign rd_last = (st_q == ST_RD) && (st_d != ST_RD);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_last;
            if (rd_last) rd_data <= dq_in;
        end
    end

    // Turnaround: consecutive cycles output-enable has been high, saturating.
    logic [TCNT_W-1:0] oe_hi_q;
    logic [TCNT_W-1:0] oe_hi_inc;

    assign oe_hi_inc = !pins_q.oe_n ? '0 :
                       (oe_hi_q == TCNT_W'(TURN_CYC)) ? oe_hi_q : oe_hi_q + 1'b1;
    assign turn_ok   = (oe_hi_inc >= TCNT_W'(TURN_CYC));

    always_ff @(posedge clk) begin
        if (rst) oe_hi_q <= '0;
        else     oe_hi_q <= oe_hi_inc;
    end

    // Checker counter: length of the current low write-strobe run.
    logic [WCNT_W-1:0] we_lo_q;
    always_ff @(posedge clk) begin
        if (rst)                                  we_lo_q <= '0;
        else if (pins_q.we_n)                     we_lo_q <= '0;
        else if (we_lo_q != WCNT_W'(WP_CYC + 1))  we_lo_q <= we_lo_q + 1'b1;
    end

    a_r5_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (we_lo_q >= WCNT_W'(WP_CYC)));

    a_r6_drive_needs_oe_high: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (oe_n && !ce_n));

    a_r6_release_at_we_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> !dq_oe);

    a_r7_turnaround_met: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> (oe_hi_q >= TCNT_W'(TURN_CYC)));

    a_r8_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (oe_n && !ce_n));

    a_r4_rd_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
    import async_sram_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 8,
    parameter int CLK_NS  = 10,
    parameter int T_AA_NS = 10,
    parameter int T_OE_NS = 4,
    parameter int T_WP_NS = 8,
    parameter int T_DS_NS = 6,
    parameter int T_SA_NS = 0,
    parameter int T_WC_NS = 10,
    parameter int T_HZ_NS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              sram_dq_oe,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    localparam int AS_CYC   = at_least_one(ns_to_cyc(T_SA_NS, CLK_NS));
    localparam int WP_CYC   = at_least_one(max2(ns_to_cyc(T_WP_NS, CLK_NS),
                                                ns_to_cyc(T_DS_NS, CLK_NS)));
    localparam int REC_CYC  = at_least_one(ns_to_cyc(T_WC_NS, CLK_NS) - AS_CYC - WP_CYC);
    localparam int RD_CYC   = at_least_one(max2(ns_to_cyc(T_AA_NS, CLK_NS),
                                                ns_to_cyc(T_OE_NS, CLK_NS))) + 1;
    localparam int TURN_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int LONGEST  = max2(max2(AS_CYC, WP_CYC), max2(REC_CYC, RD_CYC));
    localparam int CNT_W    = $clog2(LONGEST + 1);

    seq_state_t       st_q;
    seq_state_t       st_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             phase_done;
    logic             turn_ok;
    logic             accept;

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .AS_CYC (AS_CYC),
        .WP_CYC (WP_CYC),
        .REC_CYC(REC_CYC),
        .RD_CYC (RD_CYC)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .phase_done(phase_done),
        .turn_ok   (turn_ok),
        .st_q      (st_q),
        .st_d      (st_d),
        .ld        (ld),
        .ld_val    (ld_val),
        .req_ready (req_ready),
        .accept    (accept)
    );

    sram_phase_timer #(
        .CNT_W(CNT_W)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .load_val(ld_val),
        .done    (phase_done)
    );

    sram_pin_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .TURN_CYC(TURN_CYC),
        .WP_CYC  (WP_CYC)
    ) pins_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .st_q     (st_q),
        .st_d     (st_d),
        .dq_in    (sram_dq_in),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .dq_oe    (sram_dq_oe),
        .addr     (sram_addr),
        .dq_out   (sram_dq_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .turn_ok  (turn_ok)
    );

    // R1: the chip is never selected out of reset
    a_r1_reset_deselects: assert property (@(posedge clk)
        rst |=> (sram_ce_n && sram_we_n && !sram_dq_oe));

    // R2: idle means deselected and driver off
    a_r2_ready_deselects: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

endmodule

// File: tb/async_sram_ctrl_tb_top.sv
module async_sram_ctrl_tb_top;

    localparam int TB_CLK_NS = 20;
    localparam int AA_NS     = 50;
    localparam int HZ_NS     = 30;
    // Expected cycle counts derived from the requirements and the ns limits.
    localparam int RD_LAT    = (AA_NS + TB_CLK_NS - 1) / TB_CLK_NS + 1;  // R4
    localparam int ACC_CYC   = (AA_NS + TB_CLK_NS - 1) / TB_CLK_NS;      // model access
    localparam int TURN      = (HZ_NS + TB_CLK_NS - 1) / TB_CLK_NS;      // R7
    localparam int WR_LAT    = 3;                                        // R5: AS+WP+REC

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write;
    logic [18:0] req_addr;
    logic [7:0]  req_wdata;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [18:0] sram_addr;
    logic [7:0]  sram_dq_out, sram_dq_in, mdl_dq;
    logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    async_sram_ctrl #(
        .CLK_NS (TB_CLK_NS),
        .T_AA_NS(AA_NS),
        .T_HZ_NS(HZ_NS)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .sram_addr(sram_addr), .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in),
        .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    assign sram_dq_in = sram_dq_oe ? sram_dq_out : mdl_dq;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] init_val(input logic [18:0] a);
        return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'h5A;
    endfunction

    // ---------------- memory model ----------------
    logic [7:0] mdl_mem [logic [18:0]];
    logic [7:0] exp_mem [logic [18:0]];

    function automatic logic [7:0] mdl_get(input logic [18:0] a);
        return mdl_mem.exists(a) ? mdl_mem[a] : init_val(a);
    endfunction

    function automatic logic [7:0] exp_get(input logic [18:0] a);
        return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
    endfunction

    int          acc_cnt = 0;
    int          busy    = 0;
    int          wl_cnt  = 0;
    logic [18:0] w_addr;
    logic [7:0]  w_data;

    always @(posedge clk) begin
        if (!rst) begin
            if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
                acc_cnt = acc_cnt + 1;
                if (sram_dq_oe) chk(0, "R7 contention during read", 1, 0);
                busy = TURN;
            end else begin
                acc_cnt = 0;
                if (sram_dq_oe && busy != 0) chk(0, "R7 contention in release window", busy, 0);
                if (busy != 0) busy = busy - 1;
            end
            if (!sram_ce_n && !sram_we_n) begin
                wl_cnt = wl_cnt + 1;
                w_addr = sram_addr;
                w_data = sram_dq_out;
                if (!sram_dq_oe) chk(0, "R6 data not driven while strobe low", 0, 1);
                if (!sram_oe_n) chk(0, "R8 oe low during write", 0, 1);
            end else if (wl_cnt != 0) begin
                if (wl_cnt * TB_CLK_NS < 8) chk(0, "R5 strobe width ns", wl_cnt * TB_CLK_NS, 8);
                mdl_mem[w_addr] = w_data;
                wl_cnt = 0;
            end
        end else begin
            acc_cnt = 0; busy = 0; wl_cnt = 0;
        end
    end

    always @(negedge clk) begin
        if (!sram_ce_n && !sram_oe_n && sram_we_n)
            mdl_dq = (acc_cnt >= ACC_CYC - 1) ? mdl_get(sram_addr) : ~mdl_get(sram_addr);
        else
            mdl_dq = 8'h00;
    end

    // R2 monitor: idle implies deselected
    always @(negedge clk) begin
        if (!rst && req_ready)
            chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe, "R2 idle deselect",
                {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 4'b1110);
    end

    // ---------------- host tasks ----------------
    task automatic wait_ready_accept();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [18:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        wait_ready_accept();
        exp_mem[a] = d;
        req_valid = 0; req_addr = ~a; req_wdata = ~d;   // R3: must be ignored
        chk(!req_ready, "R3 ready low while busy", req_ready, 0);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        chk(n == WR_LAT, "R5 write busy cycles", n, WR_LAT);
    endtask

    task automatic do_read(input logic [18:0] a);
        int n;
        logic [7:0] e;
        e = exp_get(a);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 8'($urandom);
        wait_ready_accept();
        req_valid = 0; req_addr = ~a;                   // R3: must be ignored
        n = 0;
        while (!rd_valid && n < 50) begin @(negedge clk); n++; end
        chk(rd_data == e, "R9 read data", rd_data, e);
        chk(n == RD_LAT, "R4 read latency", n, RD_LAT);
        @(negedge clk);
        chk(!rd_valid, "R4 rd_valid one cycle", rd_valid, 0);
    endtask

    // Read immediately followed by a write held pending (turnaround path).
    task automatic read_then_write(input logic [18:0] ra, input logic [18:0] wa,
                                   input logic [7:0] wd);
        int n;
        logic [7:0] e, got;
        bit seen;
        e = exp_get(ra);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = ra;
        wait_ready_accept();
        req_write = 1; req_addr = wa; req_wdata = wd;
        seen = 0; got = 0;
        while (!req_ready) @(negedge clk);
        if (rd_valid) begin seen = 1; got = rd_data; end
        @(negedge clk);
        exp_mem[wa] = wd;
        req_valid = 0;
        chk(seen && got == e, "R9 read before pending write", got, e);
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        chk(n == WR_LAT + TURN - 1, "R7 write after read waits turnaround", n, WR_LAT + TURN - 1);
    endtask

    // Write immediately followed by a pending read of the same address.
    task automatic write_then_read(input logic [18:0] a, input logic [7:0] d);
        int n;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        wait_ready_accept();
        exp_mem[a] = d;
        req_write = 0; req_wdata = ~d;
        wait_ready_accept();
        req_valid = 0; req_addr = ~a;
        n = 0;
        while (!rd_valid && n < 50) begin @(negedge clk); n++; end
        chk(rd_data == d, "R9 back-to-back read after write", rd_data, d);
        chk(n == RD_LAT, "R4 latency back-to-back", n, RD_LAT);
    endtask

    // ---------------- stimulus ----------------
    logic [18:0] pool [8];

    initial begin
        pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001; pool[3] = 19'h40000;
        pool[4] = 19'h2AAAA; pool[5] = 19'h15555; pool[6] = 19'h00100; pool[7] = 19'h7FF00;
        void'($urandom(32'h1234_5678));
        rst = 1; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        repeat (3) begin
            @(negedge clk);
            chk(sram_ce_n && sram_we_n && !sram_dq_oe, "R1 deselected in reset",
                {sram_ce_n, sram_we_n, sram_dq_oe}, 3'b110);
        end
        rst = 0;
        @(negedge clk);
        chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && req_ready && !rd_valid,
            "R1 state after reset",
            {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, req_ready, rd_valid}, 6'b111010);

        do_read(19'h00000);                 // R9 unwritten content
        do_write(19'h00000, 8'hA5);
        do_read(19'h00000);
        do_write(19'h7FFFF, 8'h3C);
        do_read(19'h7FFFF);
        do_read(19'h7FFFE);                 // R3: stale address not written
        write_then_read(19'h12345, 8'hC3);
        read_then_write(19'h12345, 19'h12345, 8'h0F);
        do_read(19'h12345);
        read_then_write(19'h00001, 19'h00002, 8'hFF);
        do_read(19'h00002);

        for (int i = 0; i < 200; i++) begin
            logic [18:0] a;
            logic [7:0] d;
            int kind;
            a = ($urandom % 4 != 0) ? pool[$urandom % 8] : 19'($urandom);
            d = 8'($urandom);
            kind = $urandom % 4;
            case (kind)
                0: do_write(a, d);
                1: do_read(a);
                2: write_then_read(a, d);
                default: read_then_write(a, pool[$urandom % 8], d);
            endcase
        end

        for (int i = 0; i < 8; i++) do_read(pool[i]);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule